// File: doc/BRIEF.md
# GPIO Interrupt Bank

This block is one bank of general-purpose pins. It sits behind a simple register interface that is written in a single cycle and read combinationally. Software drives the pins through an output-value register and an output-enable register. It reads the pins back through a synchronized input register. Any pin can also serve as an interrupt source: a routing mask picks which pins feed the event logic, and an enable mask picks which latched events may reach the interrupt lines.

Each pin has a two-bit trigger code, made of a sense bit and a polarity bit. The code selects falling edge, low level, rising edge or high level. A detected event sets a sticky status bit, and only an explicit clear removes it. Every writable register answers at three word addresses: a plain write, a set write (ORs the ones in) and a clear write (removes the ones). The status register is driven by hardware and responds only to the clear write. The combined interrupt can be one line for the whole bank. With `SPLIT_UPPER` set, it becomes two lines: one for the lower half of the pins and one for the upper half.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero, `pad_out_o` and `pad_oe_o` are zero, and both interrupt lines are low.
- R2: The byte address splits into three fields. `bus_addr_i[7:4]` selects the register: 0 output value, 1 input value, 2 output enable, 3 route mask, 4 enable mask, 5 sense, 6 polarity, 7 status. `bus_addr_i[3:2]` selects the write kind: 0 plain, 1 set, 2 clear, 3 ignored. `bus_addr_i[1:0]` must be zero for a write to take effect. A read returns the selected register whatever the write kind. Writes to the input value register have no effect.
- R3: On a writable register, a plain write loads the data, a set write ORs the data in, and a clear write ANDs the inverted data in.
- R4: `pad_out_o` always equals the output value register and `pad_oe_o` always equals the output enable register.
- R5: The input value register shows a pin level two clock edges after it is applied. After one edge it still reads the old level.
- R6: The trigger code is {polarity, sense}. 0 latches on a falling edge, 1 on a low level, 2 on a rising edge and 3 on a high level. The opposite edge, and the inactive level, latch nothing.
- R7: A status bit is set only while the route mask bit for that pin is 1.
- R8: Status bits are removed only by a clear write to the status register, and only for the bits written as one. Plain writes and set writes to the status register leave it unchanged.
- R9: In a level mode, a status bit cannot be cleared while its active level is still present on the pin. It stays set until the pin goes inactive and a clear follows.
- R10: An interrupt line is high exactly when some pin it covers has its status, enable and route bits all set.
- R11: With `SPLIT_UPPER` = 1, pins 0 to 15 drive `irq_main_o` and pins 16 to 31 drive `irq_upper_o`. With `SPLIT_UPPER` = 0, all pins drive `irq_main_o` and `irq_upper_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle |
| bus_addr_i | input | 8 | Byte address: register index, write kind, zero offset |
| bus_wdata_i | input | 32 | Write data, one bit per pin |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| pad_in_i | input | 32 | Pin levels from the pads, asynchronous |
| pad_out_o | output | 32 | Pin output values |
| pad_oe_o | output | 32 | Pin output enables, 1 drives the pad |
| irq_main_o | output | 1 | Bank interrupt, or lower half when split |
| irq_upper_o | output | 1 | Upper-half interrupt when split, else low |

## Verification
The bench sweeps every pin through all four trigger codes. Each pin starts at its inactive level and is then driven active, inactive, and cleared along the way. This separates edge from level behaviour, shows that the opposite edge is ignored, and shows that a level event survives a clear while the level lasts. Each event is checked against the full 32-bit status word, so a bit landing on the wrong pin is caught. Both the split and the single-line interrupt arrangements are checked. Separate patterns write set, clear, plain and ignored kinds to each writable register. Other patterns gate the route and enable masks independently to tell a latching failure from a masking failure, and a two-step pin pattern checks the synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register index field width and full byte-address width of the bank.
    localparam int REG_IDX_W  = 4;
    localparam int BUS_ADDR_W = REG_IDX_W + 4;

    typedef enum logic [1:0] {
        ALIAS_WRITE = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLEAR = 2'd2,
        ALIAS_NONE  = 2'd3
    } alias_e;

    typedef enum logic [REG_IDX_W-1:0] {
        REG_DOUT   = 4'd0,
        REG_DIN    = 4'd1,
        REG_DOE    = 4'd2,
        REG_ROUTE  = 4'd3,
        REG_IEN    = 4'd4,
        REG_LEVEL  = 4'd5,
        REG_POLAR  = 4'd6,
        REG_STATUS = 4'd7
    } reg_sel_e;

    // Trigger code is {polarity, sense}.
    typedef enum logic [1:0] {
        TRIG_FALL_EDGE  = 2'd0,
        TRIG_LOW_LEVEL  = 2'd1,
        TRIG_RISE_EDGE  = 2'd2,
        TRIG_HIGH_LEVEL = 2'd3
    } trig_e;

    localparam int RW_COUNT = 6;

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_bank_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_i,
    input  alias_e       kind_i,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] q_d;

    always_comb begin
        q_d = q_o;
        unique case (kind_i)
            ALIAS_WRITE: q_d = data_i;
            ALIAS_SET:   q_d = q_o | data_i;
            ALIAS_CLEAR: q_d = q_o & ~data_i;
            default:     q_d = q_o;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q_o <= '0;
        end else if (wr_i) begin
            q_o <= q_d;
        end
    end

    // R3: a set write leaves every written one set.
    p_set_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && kind_i == ALIAS_SET) |=> ((q_o & $past(data_i)) == $past(data_i)));

    // R3: a clear write leaves every written one cleared.
    p_clear_alias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && kind_i == ALIAS_CLEAR) |=> ((q_o & $past(data_i)) == '0));

    // R2: ignored write kind holds the value.
    p_none_alias_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && kind_i == ALIAS_NONE) |=> (q_o == $past(q_o)));

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  wr_i,
    input  logic [BUS_ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]      wdata_i,
    input  logic [NPINS-1:0]      din_i,
    input  logic [NPINS-1:0]      status_i,
    output logic [NPINS-1:0]      rdata_o,
    output logic [NPINS-1:0]      dout_o,
    output logic [NPINS-1:0]      doe_o,
    output logic [NPINS-1:0]      route_o,
    output logic [NPINS-1:0]      ien_o,
    output logic [NPINS-1:0]      level_o,
    output logic [NPINS-1:0]      polar_o,
    output logic                  clr_stb_o,
    output logic [NPINS-1:0]      clr_mask_o
);

    localparam int IDX_LSB = BUS_ADDR_W - REG_IDX_W;

    reg_sel_e                     sel;
    alias_e                       kind;
    logic                         word_ok;
    logic                         wr_ok;
    logic [RW_COUNT-1:0][NPINS-1:0] rw_q;

    assign sel     = reg_sel_e'(addr_i[BUS_ADDR_W-1:IDX_LSB]);
    assign kind    = alias_e'(addr_i[3:2]);
    assign word_ok = (addr_i[1:0] == 2'b00);
    assign wr_ok   = wr_i && word_ok;

    function automatic reg_sel_e rw_slot(input int k);
        unique case (k)
            0:       return REG_DOUT;
            1:       return REG_DOE;
            2:       return REG_ROUTE;
            3:       return REG_IEN;
            4:       return REG_LEVEL;
            default: return REG_POLAR;
        endcase
    endfunction

    for (genvar k = 0; k < RW_COUNT; k++) begin : g_rw
        gpio_alias_reg #(
            .W (NPINS)
        ) u_reg (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .wr_i   (wr_ok && (sel == rw_slot(k))),
            .kind_i (kind),
            .data_i (wdata_i),
            .q_o    (rw_q[k])
        );
    end

    assign dout_o  = rw_q[0];
    assign doe_o   = rw_q[1];
    assign route_o = rw_q[2];
    assign ien_o   = rw_q[3];
    assign level_o = rw_q[4];
    assign polar_o = rw_q[5];

    // Only the clear kind reaches the hardware-owned status register.
    assign clr_stb_o  = wr_ok && (sel == REG_STATUS) && (kind == ALIAS_CLEAR);
    assign clr_mask_o = wdata_i;

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            REG_DOUT:   rdata_o = rw_q[0];
            REG_DIN:    rdata_o = din_i;
            REG_DOE:    rdata_o = rw_q[1];
            REG_ROUTE:  rdata_o = rw_q[2];
            REG_IEN:    rdata_o = rw_q[3];
            REG_LEVEL:  rdata_o = rw_q[4];
            REG_POLAR:  rdata_o = rw_q[5];
            REG_STATUS: rdata_o = status_i;
            default:    rdata_o = '0;
        endcase
    end

    // R8: a clear strobe can only come from a status-register clear write.
    p_clear_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_stb_o |-> (wr_i && addr_i[BUS_ADDR_W-1:IDX_LSB] == 4'd7 && addr_i[3:2] == 2'd2));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= pins_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

    if (STAGES == 2) begin : g_chk
        logic [1:0] warm_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                warm_q <= '0;
            end else if (warm_q != 2'd2) begin
                warm_q <= warm_q + 2'd1;
            end
        end

        // R5: synchronized value is the pin level from two edges back.
        p_sync_latency_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (warm_q == 2'd2) |-> (sync_o == $past(pins_i, 2)));
    end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
    import gpio_bank_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] sync_i,
    input  logic [NPINS-1:0] route_i,
    input  logic [NPINS-1:0] level_i,
    input  logic [NPINS-1:0] polar_i,
    input  logic             clr_stb_i,
    input  logic [NPINS-1:0] clr_mask_i,
    output logic [NPINS-1:0] status_o
);

    logic [NPINS-1:0] prev_q;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] keep;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        trig_e mode;
        logic  raw;
        assign mode = trig_e'({polar_i[i], level_i[i]});

        always_comb begin
            unique case (mode)
                TRIG_FALL_EDGE:  raw = prev_q[i] & ~sync_i[i];
                TRIG_LOW_LEVEL:  raw = ~sync_i[i];
                TRIG_RISE_EDGE:  raw = sync_i[i] & ~prev_q[i];
                TRIG_HIGH_LEVEL: raw = sync_i[i];
                default:         raw = 1'b0;
            endcase
        end

        assign hit[i] = raw & route_i[i];
    end

    assign keep = clr_stb_i ? (status_q & ~clr_mask_i) : status_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= sync_i;
            status_q <= keep | hit;
        end
    end

    assign status_o = status_q;

    // R8: without a clear strobe no status bit falls.
    p_status_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clr_stb_i |=> (($past(status_q) & ~status_q) == '0));

    // R7: no bit rises on a pin that was not routed.
    p_unrouted_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_q & ~$past(status_q) & ~$past(route_i)) == '0));

    // R6: a routed rising edge in rising mode is latched.
    p_rise_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(route_i & ~level_i & polar_i & sync_i & ~prev_q) & ~status_q) == '0));

    // R9: a routed active level keeps its bit set even across a clear.
    p_level_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (($past(route_i & level_i & ~(sync_i ^ polar_i)) & ~status_q) == '0));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
    parameter int NPINS       = 32,
    parameter bit SPLIT_UPPER = 1'b1
) (
    input  logic [NPINS-1:0] status_i,
    input  logic [NPINS-1:0] ien_i,
    input  logic [NPINS-1:0] route_i,
    output logic             irq_main_o,
    output logic             irq_upper_o
);

    localparam int HALF = NPINS / 2;

    logic [NPINS-1:0] live;
    assign live = status_i & ien_i & route_i;

    if (SPLIT_UPPER) begin : g_split
        assign irq_main_o  = |live[HALF-1:0];
        assign irq_upper_o = |live[NPINS-1:HALF];
    end else begin : g_single
        assign irq_main_o  = |live;
        assign irq_upper_o = 1'b0;
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter bit SPLIT_UPPER = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bus_wr_i,
    input  logic [BUS_ADDR_W-1:0] bus_addr_i,
    input  logic [NPINS-1:0]      bus_wdata_i,
    output logic [NPINS-1:0]      bus_rdata_o,
    input  logic [NPINS-1:0]      pad_in_i,
    output logic [NPINS-1:0]      pad_out_o,
    output logic [NPINS-1:0]      pad_oe_o,
    output logic                  irq_main_o,
    output logic                  irq_upper_o
);

    logic [NPINS-1:0] din;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] route;
    logic [NPINS-1:0] ien;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] polar;
    logic             clr_stb;
    logic [NPINS-1:0] clr_mask;

    gpio_in_sync #(
        .W      (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pins_i (pad_in_i),
        .sync_o (din)
    );

    gpio_ctrl_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (bus_wr_i),
        .addr_i     (bus_addr_i),
        .wdata_i    (bus_wdata_i),
        .din_i      (din),
        .status_i   (status),
        .rdata_o    (bus_rdata_o),
        .dout_o     (pad_out_o),
        .doe_o      (pad_oe_o),
        .route_o    (route),
        .ien_o      (ien),
        .level_o    (level),
        .polar_o    (polar),
        .clr_stb_o  (clr_stb),
        .clr_mask_o (clr_mask)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_i     (din),
        .route_i    (route),
        .level_i    (level),
        .polar_i    (polar),
        .clr_stb_i  (clr_stb),
        .clr_mask_i (clr_mask),
        .status_o   (status)
    );

    gpio_irq_merge #(
        .NPINS       (NPINS),
        .SPLIT_UPPER (SPLIT_UPPER)
    ) u_merge (
        .status_i    (status),
        .ien_i       (ien),
        .route_i     (route),
        .irq_main_o  (irq_main_o),
        .irq_upper_o (irq_upper_o)
    );

    // R10: an interrupt line needs some pin with both masks open.
    p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_main_o || irq_upper_o) |-> ((ien & route & status) != '0));

    // R11: the upper line is silent in the single-line arrangement.
    p_upper_silent_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !SPLIT_UPPER |-> !irq_upper_o);

endmodule

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

    localparam int A_DOUT = 0, A_DIN = 1, A_DOE = 2, A_ROUTE = 3;
    localparam int A_IEN = 4, A_LEV = 5, A_POL = 6, A_STAT = 7;
    localparam int K_PLAIN = 0, K_SET = 1, K_CLR = 2, K_NONE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] pins = '0;
    logic [31:0] rd_s, rd_f, out_s, oe_s, out_f, oe_f;
    logic        main_s, up_s, main_f, up_f;
    int          n_chk = 0;
    int          n_err = 0;

    always #10 clk = ~clk;

    gpio_irq_bank #(.NPINS(32), .SPLIT_UPPER(1'b1), .SYNC_STAGES(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rd_s), .pad_in_i(pins),
        .pad_out_o(out_s), .pad_oe_o(oe_s), .irq_main_o(main_s), .irq_upper_o(up_s));

    gpio_irq_bank #(.NPINS(32), .SPLIT_UPPER(1'b0), .SYNC_STAGES(2)) dut_flat (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rd_f), .pad_in_i(pins),
        .pad_out_o(out_f), .pad_oe_o(oe_f), .irq_main_o(main_f), .irq_upper_o(up_f));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int idx, input int kind, input logic [31:0] d);
        @(negedge clk);
        wr    = 1'b1;
        addr  = {idx[3:0], kind[1:0], 2'b00};
        wdata = d;
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rreg(input int idx, output logic [31:0] v);
        addr = {idx[3:0], 4'b0000};
        #1;
        v = rd_s;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rreg(i, v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset outputs", out_s | oe_s, 32'h0);
        chk("R1 reset irq", {30'd0, main_s, up_s}, 32'h0);

        // R2, R3: write kinds on every writable register
        for (int j = 0; j < 6; j++) begin
            int idx;
            idx = (j == 0) ? A_DOUT : (j == 1) ? A_DOE : (j == 2) ? A_ROUTE :
                  (j == 3) ? A_IEN : (j == 4) ? A_LEV : A_POL;
            exp = 32'hA5A5_0F0F;
            wreg(idx, K_PLAIN, exp);
            rreg(idx, v); chk("R3 plain write", v, exp);
            wreg(idx, K_SET, 32'h0000_F0F0);
            exp = exp | 32'h0000_F0F0;
            rreg(idx, v); chk("R3 set write", v, exp);
            wreg(idx, K_CLR, 32'hA500_00FF);
            exp = exp & ~32'hA500_00FF;
            rreg(idx, v); chk("R3 clear write", v, exp);
            wreg(idx, K_NONE, 32'hFFFF_FFFF);
            rreg(idx, v); chk("R2 ignored kind", v, exp);
            @(negedge clk);
            wr = 1'b1; addr = {idx[3:0], 2'b00, 2'b01}; wdata = 32'h0;
            @(negedge clk);
            wr = 1'b0;
            rreg(idx, v); chk("R2 unaligned write ignored", v, exp);
            addr = {idx[3:0], 2'b10, 2'b00}; #1;
            chk("R2 read through clear address", rd_s, exp);
            wreg(idx, K_PLAIN, 32'h0);
        end

        // R4: pad drive follows output registers
        wreg(A_DOUT, K_PLAIN, 32'h1234_5678);
        wreg(A_DOE, K_PLAIN, 32'hFF00_FF00);
        chk("R4 pad out", out_s, 32'h1234_5678);
        chk("R4 pad oe", oe_s, 32'hFF00_FF00);
        wreg(A_DOE, K_CLR, 32'hF000_0000);
        chk("R4 pad oe after clear", oe_s, 32'h0F00_FF00);
        wreg(A_DOUT, K_PLAIN, 32'h0);
        wreg(A_DOE, K_PLAIN, 32'h0);

        // R5: two-edge synchronizer latency
        @(negedge clk);
        pins = 32'hDEAD_BEEF;
        @(negedge clk);
        rreg(A_DIN, v); chk("R5 one edge old value", v, 32'h0);
        @(negedge clk);
        rreg(A_DIN, v); chk("R5 two edges new value", v, 32'hDEAD_BEEF);
        wreg(A_DIN, K_PLAIN, 32'h0);
        rreg(A_DIN, v); chk("R2 input register write ignored", v, 32'hDEAD_BEEF);
        pins = 32'h0;
        cyc(4);

        // R7: unrouted pin does not latch
        wreg(A_IEN, K_SET, 32'h8);
        wreg(A_POL, K_SET, 32'h8);
        pins = 32'h8;
        cyc(4);
        rreg(A_STAT, v); chk("R7 unrouted no status", v, 32'h0);
        chk("R7 unrouted no irq", {30'd0, main_s, main_f}, 32'h0);
        pins = 32'h0;
        cyc(4);
        wreg(A_ROUTE, K_SET, 32'h8);
        pins = 32'h8;
        cyc(4);
        rreg(A_STAT, v); chk("R7 routed rising latched", v, 32'h8);
        chk("R10 irq with masks open", {30'd0, main_s, main_f}, 32'h3);

        // R10: each mask gates the line on its own
        wreg(A_IEN, K_CLR, 32'h8);
        chk("R10 enable closed", {30'd0, main_s, main_f}, 32'h0);
        rreg(A_STAT, v); chk("R10 status kept with enable closed", v, 32'h8);
        wreg(A_IEN, K_SET, 32'h8);
        wreg(A_ROUTE, K_CLR, 32'h8);
        chk("R10 route closed", {30'd0, main_s, main_f}, 32'h0);
        wreg(A_ROUTE, K_SET, 32'h8);
        chk("R10 reopened", {30'd0, main_s, main_f}, 32'h3);

        // R8: only clear writes remove status, and only written bits
        wreg(A_STAT, K_PLAIN, 32'h0);
        rreg(A_STAT, v); chk("R8 plain write zero", v, 32'h8);
        wreg(A_STAT, K_SET, 32'hFFFF_FFFF);
        rreg(A_STAT, v); chk("R8 set write", v, 32'h8);
        wreg(A_STAT, K_CLR, 32'h10);
        rreg(A_STAT, v); chk("R8 clear other bit", v, 32'h8);
        wreg(A_STAT, K_CLR, 32'h8);
        rreg(A_STAT, v); chk("R8 clear own bit", v, 32'h0);
        wreg(A_ROUTE, K_PLAIN, 32'h0);
        wreg(A_IEN, K_PLAIN, 32'h0);
        wreg(A_POL, K_PLAIN, 32'h0);
        pins = 32'h0;
        cyc(4);

        // R6, R9, R11: every pin through every trigger code
        for (int p = 0; p < 32; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic [31:0] bm;
                logic        hi_act, lvl;
                bm     = 32'h1 << p;
                hi_act = m[1];
                lvl    = m[0];
                pins   = hi_act ? 32'h0 : bm;
                cyc(4);
                wreg(A_STAT, K_CLR, 32'hFFFF_FFFF);
                wreg(A_LEV, lvl ? K_SET : K_CLR, bm);
                wreg(A_POL, hi_act ? K_SET : K_CLR, bm);
                wreg(A_ROUTE, K_SET, bm);
                wreg(A_IEN, K_SET, bm);
                cyc(1);
                rreg(A_STAT, v); chk("R6 inactive level quiet", v, 32'h0);
                pins = hi_act ? bm : 32'h0;
                cyc(4);
                rreg(A_STAT, v); chk("R6 active transition latched", v, bm);
                chk("R11 split lines", {30'd0, main_s, up_s},
                    (p < 16) ? 32'h2 : 32'h1);
                chk("R11 single line", {30'd0, main_f, up_f}, 32'h2);
                wreg(A_STAT, K_CLR, bm);
                rreg(A_STAT, v); chk("R9 clear while active", v, lvl ? bm : 32'h0);
                pins = hi_act ? 32'h0 : bm;
                cyc(4);
                rreg(A_STAT, v); chk("R6 opposite edge or held level", v, lvl ? bm : 32'h0);
                wreg(A_STAT, K_CLR, bm);
                rreg(A_STAT, v); chk("R9 clear after inactive", v, 32'h0);
                chk("R10 lines low after clear", {28'd0, main_s, up_s, main_f, up_f}, 32'h0);
                wreg(A_ROUTE, K_CLR, 32'hFFFF_FFFF);
                wreg(A_IEN, K_CLR, 32'hFFFF_FFFF);
                wreg(A_LEV, K_CLR, 32'hFFFF_FFFF);
                wreg(A_POL, K_CLR, 32'hFFFF_FFFF);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule